// File: doc/BRIEF.md
# DAC Load Advance Timing Generator

This block decides, inside every sampling interval, when the DAC is told to take its next sample, and when the ADC signals that its output word is ready. Time is measured in ticks of the internal master clock, given as a one-cycle enable on the system clock. A pulse on `intv_start` opens an interval and resets a tick counter. The ADC output frame-sync strobe fires at a fixed tick position (`FS_POS`). The DAC load strobe fires earlier, at `FS_POS` minus one serial clock period minus eight ticks for each step of a 5-bit advance value.

Moving the load earlier shortens the group delay when the ADC result feeds the DAC path in series. The advance value is copied into a working register only while the DAC is powered down. The serial-clock rate code and that working copy are sampled once, at the start of each interval. This guarantees that every interval has exactly one load strobe and one frame-sync strobe, whatever the inputs do in the middle of an interval.

Top module: `dla_timing_gen`

## Requirements
- R1: After reset, both strobes are low, and no strobe fires on any tick before the first `intv_start` pulse.
- R2: `adc_fs` fires exactly once per interval. It fires on the tick whose index is `FS_POS`, where the first tick after `intv_start` has index 0.
- R3: With an advance of zero, `dac_load` fires at tick index `FS_POS - P`. P is the serial clock period in ticks: code 0 gives 8, code 1 gives 4, code 2 gives 2 and code 3 gives 1.
- R4: Each advance step moves `dac_load` eight ticks earlier, so its index is `FS_POS - P - 8*A`, where A is the working advance.
- R5: When `FS_POS - P - 8*A` would be negative, `dac_load` fires at tick index 0. A result of exactly 0 also fires at index 0.
- R6: `dac_load` fires exactly once per interval.
- R7: The working advance follows `adv_val` only in cycles where `dac_on` is low. A value written while `dac_on` is high has no effect on later intervals until `dac_on` falls.
- R8: Each strobe is high for exactly one clock cycle. That cycle directly follows the clock cycle in which the tick that triggers it was present.
- R9: The rate code and the working advance are sampled in the `intv_start` cycle. Changing either one mid-interval does not move the strobes of the current interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle enable marking an internal master clock tick |
| intv_start | input | 1 | Opens a new sampling interval |
| sck_rate | input | 2 | Serial clock rate code (0:/8, 1:/4, 2:/2, 3:/1 of the tick rate) |
| adv_val | input | 5 | Requested DAC load advance in 8-tick steps |
| dac_on | input | 1 | DAC power-up indication; freezes the working advance while high |
| dac_load | output | 1 | One-cycle DAC load strobe |
| adc_fs | output | 1 | One-cycle ADC output frame-sync strobe |

## Verification
The assertions assume that `intv_start` pulses are spaced at least `FS_POS + 1` ticks apart, so that each interval reaches its frame-sync tick. They also assume that `intv_start` and `tick_en` are never high in the same cycle. The stimulus keeps to both assumptions. It drives `tick_en` low in the start cycle, and it runs every interval until `FS_POS + 3` ticks have been counted. Tick density is drawn at random for each interval, so the strobes are checked against both dense and sparse tick patterns.

// File: rtl/dla_pkg.sv
package dla_pkg;

    localparam int ADV_W      = 5;
    localparam int STEP_TICKS = 8;

    typedef logic [ADV_W-1:0] adv_t;

    typedef enum logic [1:0] {
        SCK_DIV8 = 2'd0,
        SCK_DIV4 = 2'd1,
        SCK_DIV2 = 2'd2,
        SCK_DIV1 = 2'd3
    } sck_rate_e;

    typedef struct packed {
        logic load;
        logic fsync;
    } strobe_t;

    // serial clock period expressed in internal master clock ticks
    function automatic logic [3:0] sck_period(input sck_rate_e r);
        case (r)
            SCK_DIV8: return 4'd8;
            SCK_DIV4: return 4'd4;
            SCK_DIV2: return 4'd2;
            default:  return 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/dla_adv_latch.sv
module dla_adv_latch
    import dla_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dac_on,
    input  adv_t adv_in,
    output adv_t adv_work
);

    always_ff @(posedge clk) begin
        if (rst)
            adv_work <= '0;
        else if (!dac_on)
            adv_work <= adv_in;
    end

    // R7: working copy frozen while the DAC is powered
    a_r7_frozen_when_on: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dac_on)) |-> $stable(adv_work));

endmodule

// File: rtl/dla_pos_calc.sv
module dla_pos_calc
    import dla_pkg::*;
#(
    parameter int CNT_W  = 9,
    parameter int FS_POS = 200
) (
    input  adv_t             adv,
    input  sck_rate_e        rate,
    output logic [CNT_W-1:0] pos
);

    localparam int SUB_W = CNT_W + 2;

    logic [SUB_W-1:0] back_off;
    logic [SUB_W-1:0] fs_ext;

    always_comb begin
        fs_ext   = SUB_W'(FS_POS);
        back_off = SUB_W'(sck_period(rate)) + (SUB_W'(adv) * SUB_W'(STEP_TICKS));
        if (back_off > fs_ext)
            pos = '0;
        else
            pos = CNT_W'(fs_ext - back_off);
    end

    // R5: computed load index never lies past the frame-sync index
    always_comb begin
        a_r5_pos_in_range: assert (pos <= CNT_W'(FS_POS));
    end

endmodule

// File: rtl/dla_interval_ctr.sv
module dla_interval_ctr
    import dla_pkg::*;
#(
    parameter int CNT_W  = 9,
    parameter int FS_POS = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] ld_pos,
    output strobe_t          strb
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] FS_IDX  = CNT_W'(FS_POS);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ld_pos_q;
    logic             active;
    logic             ld_done;
    logic             fs_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            ld_pos_q <= '0;
            active   <= 1'b0;
            ld_done  <= 1'b0;
            fs_done  <= 1'b0;
            strb     <= '0;
        end else begin
            strb <= '0;
            if (start) begin
                cnt      <= '0;
                ld_pos_q <= ld_pos;
                active   <= 1'b1;
                ld_done  <= 1'b0;
                fs_done  <= 1'b0;
            end else if (tick && active) begin
                if (cnt != CNT_MAX)
                    cnt <= cnt + 1'b1;
                if (!ld_done && cnt == ld_pos_q) begin
                    strb.load <= 1'b1;
                    ld_done   <= 1'b1;
                end
                if (!fs_done && cnt == FS_IDX) begin
                    strb.fsync <= 1'b1;
                    fs_done    <= 1'b1;
                end
            end
        end
    end

    // R8: strobes follow a tick cycle and last one cycle
    a_r8_load_after_tick: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && strb.load) |-> $past(tick));
    a_r8_fs_after_tick: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && strb.fsync) |-> $past(tick));
    a_r8_load_width: assert property (@(posedge clk) disable iff (rst)
        strb.load |=> !strb.load);
    a_r8_fs_width: assert property (@(posedge clk) disable iff (rst)
        strb.fsync |=> !strb.fsync);
    // R2: frame sync only at its fixed index
    a_r2_fs_index: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && strb.fsync) |-> ($past(cnt) == FS_IDX));
    // R1: nothing fires before the first interval opens
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(active)) |-> (strb == '0));
    // R9: load index held for the whole interval
    a_r9_pos_held: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(start)) |-> $stable(ld_pos_q));

endmodule

// File: rtl/dla_timing_gen.sv
module dla_timing_gen
    import dla_pkg::*;
#(
    parameter int CNT_W  = 9,
    parameter int FS_POS = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       intv_start,
    input  logic [1:0] sck_rate,
    input  logic [4:0] adv_val,
    input  logic       dac_on,
    output logic       dac_load,
    output logic       adc_fs
);

    adv_t             adv_work;
    logic [CNT_W-1:0] ld_pos;
    strobe_t          strb;

    dla_adv_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .dac_on   (dac_on),
        .adv_in   (adv_val),
        .adv_work (adv_work)
    );

    dla_pos_calc #(.CNT_W(CNT_W), .FS_POS(FS_POS)) u_pos (
        .adv  (adv_work),
        .rate (sck_rate_e'(sck_rate)),
        .pos  (ld_pos)
    );

    dla_interval_ctr #(.CNT_W(CNT_W), .FS_POS(FS_POS)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_en),
        .start  (intv_start),
        .ld_pos (ld_pos),
        .strb   (strb)
    );

    assign dac_load = strb.load;
    assign adc_fs   = strb.fsync;

    // R6: load and frame sync never coincide (load is strictly earlier)
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(dac_load && adc_fs));

endmodule

// File: tb/tb_dla_timing_gen.sv
module tb_dla_timing_gen;

    localparam int CLK_P  = 10;
    localparam int FS_POS = 200;
    localparam int WDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_en;
    logic       intv_start;
    logic [1:0] sck_rate;
    logic [4:0] adv_val;
    logic       dac_on;
    logic       dac_load;
    logic       adc_fs;

    int checks = 0;
    int fails  = 0;
    int exp_adv = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dla_timing_gen #(.CNT_W(9), .FS_POS(FS_POS)) dut (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .intv_start (intv_start),
        .sck_rate   (sck_rate),
        .adv_val    (adv_val),
        .dac_on     (dac_on),
        .dac_load   (dac_load),
        .adc_fs     (adc_fs)
    );

    function automatic int per_of(input int code);
        case (code)
            0: return 8;
            1: return 4;
            2: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_pos(input int adv, input int code);
        int v;
        v = FS_POS - per_of(code) - 8 * adv;
        return (v < 0) ? 0 : v;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic set_ctrl(input int adv, input int code, input bit pwr);
        @(negedge clk);
        adv_val  = 5'(adv);
        sck_rate = 2'(code);
        dac_on   = pwr;
        if (!pwr) exp_adv = adv;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_interval(input string req, input int density, input bit mid,
                                input int mid_adv, input int mid_code);
        int expl, ticks, ld_cnt, fs_cnt, ld_at, fs_at, bad;
        bit en;
        expl = exp_pos(exp_adv, int'(sck_rate));
        @(negedge clk);
        intv_start = 1'b1;
        tick_en    = 1'b0;
        @(negedge clk);
        intv_start = 1'b0;
        ticks = 0; ld_cnt = 0; fs_cnt = 0; ld_at = -1; fs_at = -1; bad = 0;
        while (ticks <= FS_POS + 2) begin
            en = (($urandom % density) == 0);
            tick_en = en;
            if (mid && ticks == 10) begin
                adv_val  = 5'(mid_adv);
                sck_rate = 2'(mid_code);
                if (!dac_on) exp_adv = mid_adv;
            end
            @(posedge clk);
            #(CLK_P/4);
            if (dac_load) begin ld_cnt++; ld_at = ticks; if (!en) bad++; end
            if (adc_fs)   begin fs_cnt++; fs_at = ticks; if (!en) bad++; end
            if (en) ticks++;
            @(negedge clk);
        end
        tick_en = 1'b0;
        check({req, " load index"}, ld_at, expl);
        check("R6 load count", ld_cnt, 1);
        check("R2 fs index", fs_at, FS_POS);
        check("R2 fs count", fs_cnt, 1);
        check("R8 strobe alignment", bad, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; tick_en = 1'b0; intv_start = 1'b0;
        sck_rate = 2'd0; adv_val = 5'd0; dac_on = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #(CLK_P/4);
        check("R1 reset load", int'(dac_load), 0);
        check("R1 reset fs", int'(adc_fs), 0);
        begin
            int seen;
            seen = 0;
            tick_en = 1'b1;
            for (int i = 0; i < 60; i++) begin
                @(posedge clk); #(CLK_P/4);
                if (dac_load || adc_fs) seen++;
            end
            tick_en = 1'b0;
            check("R1 quiet before start", seen, 0);
        end
        // R3: zero advance for each rate code
        for (int c = 0; c < 4; c++) begin
            set_ctrl(0, c, 1'b0);
            run_interval("R3", 1 + c, 1'b0, 0, 0);
        end
        // R4: non-zero steps
        set_ctrl(1, 0, 1'b0);  run_interval("R4", 1, 1'b0, 0, 0);
        set_ctrl(23, 0, 1'b0); run_interval("R4", 2, 1'b0, 0, 0);
        set_ctrl(10, 3, 1'b0); run_interval("R4", 3, 1'b0, 0, 0);
        // R5: exact zero and clamp
        set_ctrl(24, 0, 1'b0); run_interval("R5", 1, 1'b0, 0, 0);
        set_ctrl(31, 0, 1'b0); run_interval("R5", 2, 1'b0, 0, 0);
        set_ctrl(31, 3, 1'b0); run_interval("R5", 1, 1'b0, 0, 0);
        // R7: write while powered is ignored, then taken once powered down
        set_ctrl(5, 1, 1'b0);
        set_ctrl(17, 1, 1'b1);
        run_interval("R7", 2, 1'b0, 0, 0);
        set_ctrl(17, 1, 1'b0);
        run_interval("R7", 1, 1'b0, 0, 0);
        // R9: mid-interval change does not move current strobes
        set_ctrl(3, 0, 1'b0);
        run_interval("R9", 2, 1'b1, 20, 3);
        run_interval("R9 next", 1, 1'b0, 0, 0);
        // random mix
        for (int k = 0; k < 12; k++) begin
            set_ctrl(int'($urandom % 32), int'($urandom % 4), 1'b0);
            run_interval("R4 random", 1 + int'($urandom % 3), 1'b0, 0, 0);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule